// File: doc/BRIEF.md
# Four-Stage Pipelined 8-bit Processor Core

This block is a small 8-bit processor core that executes 16-bit instructions through four overlapping stages: instruction fetch, decode with address formation, operand fetch, and execute with write-back. The program lives in a 16-word instruction store. That store is set at elaboration through a parameter vector, with word `i` at bits `[16*i+15 : 16*i]`. Data lives in an 8-bit data memory of 2^`DMEM_AW` words, which is 4096 by default. The core has sixteen 8-bit general registers, and register 0 serves as the accumulator.

The only inputs are a clock and an active-low reset. The reset asserts asynchronously and releases synchronously inside the block. The outputs are for debug: the program counter, register 0, and a halted flag. A program is placed in the parameter vector and runs from address 0 after reset. It signals completion by reaching a halt instruction. Its results are read from register 0.

Top module: `cpu8_core`

## Requirements
- R1: While reset is held, and on the first cycle after it releases, the PC, register 0 and the halted flag read zero. Fetch starts at address 0, and the PC advances by one (wrapping modulo 16) every cycle unless it is redirected.
- R2: Instruction word bits are: [15] mode, [14:12] opcode, [11:8] function, [7:4] first index, [3:0] second index. With mode 0 and opcode 001 (load-immediate), the byte {bits 7:0} is written to the register selected by bits [11:8].
- R3: With mode 0 and opcode 010, the function field selects an operation on A=R[bits 7:4] and B=R[bits 3:0], and the result goes to R[bits 7:4]. The codes are: 0 copy B, 1 A+B, 2 A+B+carry, 3 A-B-carry, 4 A-B, 6 A+1, 7 A-1, 8 bitwise NOT A, 9 AND, 10 OR, 11 XOR, 12 logical shift right of A, 13 shift left of A. Codes 5, 14 and 15 leave A unchanged.
- R4: Codes 1, 2 and 6 set the carry flag to the carry out of bit 7. Codes 3, 4 and 7 set it to the borrow. All other instructions leave the flag unchanged, and reset clears it.
- R5: With mode 1, the 12-bit address is bits [11:0]. Opcode 000 stores register 0 to data memory at that address, and opcode 001 loads that location into register 0. Addresses that differ only in the upper bits reach different locations.
- R6: With mode 1 and opcode 010 (jump), the PC is loaded from the low 4 bits of the 6-bit field bits [5:0]. Bits [11:6] are ignored. The three instructions fetched after the jump have no effect, even if one of them is a halt.
- R7: With mode 0 and opcode 000 (halt), the halted flag rises and the PC shows the address of the halt instruction. No instruction fetched after it changes any state, and the core stays frozen until reset.
- R8: An instruction that reads a register or a data memory location written by the instruction just before it sees the new value, the same as strictly sequential execution.
- R9: Opcodes 011 to 111 in either mode do nothing.
- R10: Asserting reset after a run clears the state, and the same program then runs again to the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases on the clock |
| dbg_pc | output | $clog2(IMEM_DEPTH) | Current program counter; after a halt, the halt's address |
| dbg_r0 | output | 8 | Contents of register 0 (accumulator) |
| dbg_halted | output | 1 | High once a halt instruction has executed |

## Verification
Every function code is swept against four operand and carry patterns: zero operands, an all-ones first operand with carry set, an operand pair around the sign boundary, and a pair that borrows. Each sweep program chains dependent instructions back to back, so a wrong ALU result, a wrong carry rule and a missing register forward each give a distinct value in register 0. A memory program writes two addresses that differ only in their upper bits and reloads one directly after a store to it. This separates address decoding from memory forwarding. A jump program uses high address bits that must be ignored, places a halt in the flushed shadow, and includes undefined opcodes. A second reset followed by a rerun confirms that the core restarts cleanly.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
  localparam int XLEN   = 8;
  localparam int IW     = 16;
  localparam int RIDX_W = 4;
  localparam int AR_W   = 12;
  localparam int AD_W   = 6;
  localparam int FN_W   = 4;

  // opcode values (meaning depends on the mode bit)
  localparam logic [2:0] OP_0 = 3'b000;  // halt / store
  localparam logic [2:0] OP_1 = 3'b001;  // load-imm / load
  localparam logic [2:0] OP_2 = 3'b010;  // alu / jump

  localparam logic [FN_W-1:0] F_MOV = 4'd0;
  localparam logic [FN_W-1:0] F_ADD = 4'd1;
  localparam logic [FN_W-1:0] F_ADC = 4'd2;
  localparam logic [FN_W-1:0] F_SBB = 4'd3;
  localparam logic [FN_W-1:0] F_SUB = 4'd4;
  localparam logic [FN_W-1:0] F_INC = 4'd6;
  localparam logic [FN_W-1:0] F_DEC = 4'd7;
  localparam logic [FN_W-1:0] F_CPL = 4'd8;
  localparam logic [FN_W-1:0] F_AND = 4'd9;
  localparam logic [FN_W-1:0] F_OR  = 4'd10;
  localparam logic [FN_W-1:0] F_XOR = 4'd11;
  localparam logic [FN_W-1:0] F_SHR = 4'd12;
  localparam logic [FN_W-1:0] F_SHL = 4'd13;

  typedef enum logic [2:0] {
    K_NOP, K_HLT, K_MVI, K_ALU, K_STA, K_LDA, K_JMP
  } kind_e;

  typedef struct packed {
    logic          vld;
    logic [IW-1:0] word;
  } fd_t;

  typedef struct packed {
    logic              vld;
    kind_e             kind;
    logic [RIDX_W-1:0] dst;
    logic [RIDX_W-1:0] sa;
    logic [RIDX_W-1:0] sb;
    logic [FN_W-1:0]   fn;
    logic [AR_W-1:0]   ar;
  } df_t;

  typedef struct packed {
    logic              vld;
    kind_e             kind;
    logic [RIDX_W-1:0] dst;
    logic [FN_W-1:0]   fn;
    logic [XLEN-1:0]   opa;
    logic [XLEN-1:0]   opb;
    logic [AR_W-1:0]   ar;
  } fx_t;

  function automatic df_t decode(input fd_t f);
    df_t d;
    logic       mode;
    logic [2:0] op;
    mode   = f.word[15];
    op     = f.word[14:12];
    d.vld  = f.vld;
    d.fn   = f.word[11:8];
    d.sa   = f.word[7:4];
    d.sb   = f.word[3:0];
    d.ar   = f.word[11:0];
    d.dst  = '0;
    d.kind = K_NOP;
    if (!mode) begin
      case (op)
        OP_0: d.kind = K_HLT;
        OP_1: begin d.kind = K_MVI; d.dst = f.word[11:8]; end
        OP_2: begin d.kind = K_ALU; d.dst = f.word[7:4];  end
        default: d.kind = K_NOP;
      endcase
    end else begin
      case (op)
        OP_0: d.kind = K_STA;
        OP_1: begin d.kind = K_LDA; d.dst = '0; end
        OP_2: d.kind = K_JMP;
        default: d.kind = K_NOP;
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/cpu8_rst_sync.sv
module cpu8_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stages_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stages_q <= 2'b00;
    else        stages_q <= {stages_q[0], 1'b1};
  end

  assign rst_n_sync = stages_q[1];
endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [FN_W-1:0] fn,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic            cin,
  output logic [W-1:0]    res,
  output logic            cout,
  output logic            wr,
  output logic            cupd
);
  logic [W:0] ext;
  logic [W:0] ca;
  logic [W:0] cb;
  logic [W:0] cc;

  assign ca = {1'b0, a};
  assign cb = {1'b0, b};
  assign cc = {{W{1'b0}}, cin};

  always_comb begin
    ext  = '0;
    res  = a;
    cout = cin;
    wr   = 1'b1;
    cupd = 1'b0;
    case (fn)
      F_MOV: res = b;
      F_ADD: begin ext = ca + cb;      res = ext[W-1:0]; cout = ext[W]; cupd = 1'b1; end
      F_ADC: begin ext = ca + cb + cc; res = ext[W-1:0]; cout = ext[W]; cupd = 1'b1; end
      F_SBB: begin ext = ca - cb - cc; res = ext[W-1:0]; cout = ext[W]; cupd = 1'b1; end
      F_SUB: begin ext = ca - cb;      res = ext[W-1:0]; cout = ext[W]; cupd = 1'b1; end
      F_INC: begin ext = ca + (W+1)'(1); res = ext[W-1:0]; cout = ext[W]; cupd = 1'b1; end
      F_DEC: begin ext = ca - (W+1)'(1); res = ext[W-1:0]; cout = ext[W]; cupd = 1'b1; end
      F_CPL: res = ~a;
      F_AND: res = a & b;
      F_OR:  res = a | b;
      F_XOR: res = a ^ b;
      F_SHR: res = {1'b0, a[W-1:1]};
      F_SHL: res = {a[W-2:0], 1'b0};
      default: wr = 1'b0;
    endcase
  end
endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile #(
  parameter  int NREG  = 16,
  parameter  int W     = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] wa,
  input  logic [W-1:0]     wd,
  input  logic [IDX_W-1:0] ra_a,
  input  logic [IDX_W-1:0] ra_b,
  output logic [W-1:0]     rd_a,
  output logic [W-1:0]     rd_b,
  output logic [W-1:0]     r0
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];
  assign r0   = regs[0];

  // R2: a write issued in one cycle is visible at that index the next
  p_reg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(wa)] == $past(wd));
endmodule

// File: rtl/cpu8_dmem.sv
module cpu8_dmem #(
  parameter  int AW    = 12,
  parameter  int W     = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd = mem[ra];
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter  int                        IMEM_DEPTH = 16,
  parameter  int                        DMEM_AW    = 12,
  parameter  int                        NREG       = 16,
  parameter  logic [IMEM_DEPTH*IW-1:0]  PROGRAM    = '0,
  localparam int                        PC_W       = $clog2(IMEM_DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PC_W-1:0] dbg_pc,
  output logic [XLEN-1:0] dbg_r0,
  output logic            dbg_halted
);
  logic rst_n_s;

  cpu8_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  // ---------------- state ----------------
  logic [PC_W-1:0] pc_q, pc_d;
  logic [PC_W-1:0] fd_pc_q, fd_pc_d, df_pc_q, df_pc_d, fx_pc_q, fx_pc_d;
  fd_t             fd_q, fd_d;
  df_t             df_q, df_d;
  fx_t             fx_q, fx_d;
  logic            halted_q, halted_d;
  logic            carry_q, carry_d;
  logic            stage_en;

  // ---------------- fetch ----------------
  logic [IW-1:0] fetch_word;
  always_comb fetch_word = PROGRAM[int'(pc_q)*IW +: IW];

  // ---------------- operand fetch ----------------
  logic [XLEN-1:0] rf_a, rf_b, rf_r0, mem_rd;
  logic [XLEN-1:0] fwd_a, fwd_b, fwd_r0, fwd_mem;
  logic            ex_we, ex_st;
  logic [RIDX_W-1:0] ex_wa;
  logic [XLEN-1:0] ex_wd;
  fx_t             fo_next;

  always_comb begin
    fwd_a   = (ex_we && ex_wa == df_q.sa) ? ex_wd : rf_a;
    fwd_b   = (ex_we && ex_wa == df_q.sb) ? ex_wd : rf_b;
    fwd_r0  = (ex_we && ex_wa == '0)      ? ex_wd : rf_r0;
    fwd_mem = (ex_st && fx_q.ar[DMEM_AW-1:0] == df_q.ar[DMEM_AW-1:0]) ? fx_q.opa : mem_rd;
  end

  always_comb begin
    fo_next.vld  = df_q.vld;
    fo_next.kind = df_q.kind;
    fo_next.dst  = df_q.dst;
    fo_next.fn   = df_q.fn;
    fo_next.ar   = df_q.ar;
    fo_next.opb  = fwd_b;
    case (df_q.kind)
      K_STA:   fo_next.opa = fwd_r0;
      K_MVI:   fo_next.opa = df_q.ar[XLEN-1:0];
      default: fo_next.opa = fwd_a;
    endcase
    if (df_q.kind == K_LDA) fo_next.opb = fwd_mem;
  end

  // ---------------- execute ----------------
  logic [XLEN-1:0] alu_res;
  logic            alu_cout, alu_wr, alu_cupd;
  logic            ex_alu, ex_jump, ex_halt;
  logic [PC_W-1:0] jump_pc;

  cpu8_alu #(.W(XLEN)) u_alu (
    .fn(fx_q.fn), .a(fx_q.opa), .b(fx_q.opb), .cin(carry_q),
    .res(alu_res), .cout(alu_cout), .wr(alu_wr), .cupd(alu_cupd)
  );

  always_comb begin
    ex_alu  = fx_q.vld && fx_q.kind == K_ALU;
    ex_jump = fx_q.vld && fx_q.kind == K_JMP;
    ex_halt = fx_q.vld && fx_q.kind == K_HLT;
    ex_st   = fx_q.vld && fx_q.kind == K_STA && !halted_q;
    ex_wa   = fx_q.dst;
    ex_we   = 1'b0;
    ex_wd   = alu_res;
    if (fx_q.vld && !halted_q) begin
      case (fx_q.kind)
        K_MVI: begin ex_we = 1'b1; ex_wd = fx_q.opa; end
        K_LDA: begin ex_we = 1'b1; ex_wd = fx_q.opb; end
        K_ALU: ex_we = alu_wr;
        default: ex_we = 1'b0;
      endcase
    end
    jump_pc = fx_q.ar[PC_W-1:0];
  end

  cpu8_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk(clk), .rst_n(rst_n_s),
    .we(ex_we), .wa(ex_wa), .wd(ex_wd),
    .ra_a(df_q.sa), .ra_b(df_q.sb),
    .rd_a(rf_a), .rd_b(rf_b), .r0(rf_r0)
  );

  cpu8_dmem #(.AW(DMEM_AW), .W(XLEN)) u_dmem (
    .clk(clk), .we(ex_st), .wa(fx_q.ar[DMEM_AW-1:0]), .wd(fx_q.opa),
    .ra(df_q.ar[DMEM_AW-1:0]), .rd(mem_rd)
  );

  // ---------------- next state ----------------
  assign stage_en = !halted_q;

  always_comb begin
    pc_d     = pc_q;
    fd_d     = fd_q;
    df_d     = df_q;
    fx_d     = fx_q;
    fd_pc_d  = fd_pc_q;
    df_pc_d  = df_pc_q;
    fx_pc_d  = fx_pc_q;
    halted_d = halted_q;
    carry_d  = carry_q;
    if (ex_alu && alu_cupd) carry_d = alu_cout;
    if (ex_halt) begin
      halted_d = 1'b1;
      pc_d     = fx_pc_q;
      fd_d.vld = 1'b0;
      df_d.vld = 1'b0;
      fx_d.vld = 1'b0;
    end else if (ex_jump) begin
      pc_d     = jump_pc;
      fd_d.vld = 1'b0;
      df_d.vld = 1'b0;
      fx_d.vld = 1'b0;
    end else begin
      pc_d    = pc_q + PC_W'(1);
      fd_d    = '{vld: 1'b1, word: fetch_word};
      fd_pc_d = pc_q;
      df_d    = decode(fd_q);
      df_pc_d = fd_pc_q;
      fx_d    = fo_next;
      fx_pc_d = df_pc_q;
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pc_q     <= '0;
      fd_q     <= '0;
      df_q     <= '0;
      fx_q     <= '0;
      fd_pc_q  <= '0;
      df_pc_q  <= '0;
      fx_pc_q  <= '0;
      halted_q <= 1'b0;
      carry_q  <= 1'b0;
    end else if (stage_en) begin
      pc_q     <= pc_d;
      fd_q     <= fd_d;
      df_q     <= df_d;
      fx_q     <= fx_d;
      fd_pc_q  <= fd_pc_d;
      df_pc_q  <= df_pc_d;
      fx_pc_q  <= fx_pc_d;
      halted_q <= halted_d;
      carry_q  <= carry_d;
    end
  end

  logic unused_addr_bits;
  assign unused_addr_bits = ^{fx_q.ar, df_q.ar};

  assign dbg_pc     = pc_q;
  assign dbg_r0     = rf_r0;
  assign dbg_halted = halted_q;

  // ---------------- assertions ----------------
  p_pc_step_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!halted_q && !ex_halt && !ex_jump) |=> pc_q == $past(pc_q) + PC_W'(1));

  p_jump_flush_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!halted_q && ex_jump) |=>
      (pc_q == $past(fx_q.ar[PC_W-1:0])) && !fd_q.vld && !df_q.vld && !fx_q.vld);

  p_halt_enter_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!halted_q && ex_halt) |=> halted_q && pc_q == $past(fx_pc_q));

  p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    halted_q |=> halted_q && $stable(pc_q) && $stable(carry_q) && $stable(rf_r0));
endmodule

// File: tb/test_cpu8_core.sv
`timescale 1ns/1ps
module test_cpu8_core;
  localparam int NSW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   n_chk = 0;
  int   n_fail = 0;

  always #2 clk = ~clk;

  // ---------- small assembler ----------
  function automatic logic [15:0] a_mvi(input int d, input int imm);
    return 16'h1000 | 16'((d & 15) << 8) | 16'(imm & 255);
  endfunction
  function automatic logic [15:0] a_alu(input int f, input int ra, input int rb);
    return 16'h2000 | 16'((f & 15) << 8) | 16'((ra & 15) << 4) | 16'(rb & 15);
  endfunction

  function automatic logic [7:0] pat_a(input int p);
    case (p) 0: return 8'h00; 1: return 8'hFF; 2: return 8'h80; default: return 8'h3C; endcase
  endfunction
  function automatic logic [7:0] pat_b(input int p);
    case (p) 0: return 8'h00; 1: return 8'h01; 2: return 8'h7F; default: return 8'hA5; endcase
  endfunction
  function automatic logic pat_c(input int p);
    return (p == 1 || p == 2);
  endfunction

  function automatic logic [255:0] sweep_prog(input int f, input int p);
    logic [255:0] v;
    v = '0;
    v[0*16 +: 16] = a_mvi(3, 8'hFF);
    v[1*16 +: 16] = a_mvi(4, int'(pat_c(p)));
    v[2*16 +: 16] = a_alu(1, 3, 4);          // ADD R3,R4 -> carry = cin
    v[3*16 +: 16] = a_mvi(1, int'(pat_a(p)));
    v[4*16 +: 16] = a_mvi(2, int'(pat_b(p)));
    v[5*16 +: 16] = a_alu(f, 1, 2);
    v[6*16 +: 16] = a_alu(0, 0, 1);          // copy R1 to R0
    v[7*16 +: 16] = 16'h0000;
    return v;
  endfunction

  function automatic logic [255:0] mem_prog();
    logic [255:0] v;
    v = '0;
    v[0*16 +: 16]  = a_mvi(0, 8'h11);
    v[1*16 +: 16]  = 16'h82AB;
    v[2*16 +: 16]  = a_mvi(0, 8'h22);
    v[3*16 +: 16]  = 16'h80AB;
    v[4*16 +: 16]  = a_mvi(0, 8'h77);
    v[5*16 +: 16]  = 16'h82AB;
    v[6*16 +: 16]  = 16'h92AB;
    v[7*16 +: 16]  = a_alu(0, 5, 0);
    v[8*16 +: 16]  = 16'h90AB;
    v[9*16 +: 16]  = a_alu(1, 0, 5);
    v[10*16 +: 16] = 16'h0000;
    v[11*16 +: 16] = a_mvi(0, 8'hEE);
    return v;
  endfunction

  function automatic logic [255:0] jmp_prog();
    logic [255:0] v;
    v = '0;
    v[0*16 +: 16]  = a_mvi(0, 8'h01);
    v[1*16 +: 16]  = 16'hAFF6;
    v[2*16 +: 16]  = a_mvi(0, 8'hE2);
    v[3*16 +: 16]  = a_mvi(0, 8'hE3);
    v[4*16 +: 16]  = a_mvi(0, 8'hE4);
    v[5*16 +: 16]  = 16'h0000;
    v[6*16 +: 16]  = a_alu(6, 0, 0);
    v[7*16 +: 16]  = 16'hA00A;
    v[8*16 +: 16]  = a_mvi(0, 8'hE8);
    v[9*16 +: 16]  = 16'h0000;
    v[10*16 +: 16] = a_alu(6, 0, 0);
    v[11*16 +: 16] = 16'h3000;
    v[12*16 +: 16] = 16'hF123;
    v[13*16 +: 16] = a_alu(6, 0, 0);
    v[14*16 +: 16] = 16'h0000;
    return v;
  endfunction

  // reference arithmetic taken from R3/R4
  function automatic logic [7:0] alu_ref(input int f, input logic [7:0] a,
                                         input logic [7:0] b, input logic c);
    case (f)
      0:  return b;
      1:  return 8'(a + b);
      2:  return 8'(a + b + 8'(c));
      3:  return 8'(a - b - 8'(c));
      4:  return 8'(a - b);
      6:  return 8'(a + 1);
      7:  return 8'(a - 1);
      8:  return ~a;
      9:  return a & b;
      10: return a | b;
      11: return a ^ b;
      12: return a >> 1;
      13: return 8'(a << 1);
      default: return a;
    endcase
  endfunction

  // ---------- devices ----------
  logic [3:0] m_pc, j_pc;
  logic [7:0] m_r0, j_r0;
  logic       m_h, j_h;

  cpu8_core #(.PROGRAM(mem_prog())) i_cpu8_core (
    .clk(clk), .rst_n(rst_n), .dbg_pc(m_pc), .dbg_r0(m_r0), .dbg_halted(m_h));

  cpu8_core #(.DMEM_AW(4), .PROGRAM(jmp_prog())) i_cpu8_core_jmp (
    .clk(clk), .rst_n(rst_n), .dbg_pc(j_pc), .dbg_r0(j_r0), .dbg_halted(j_h));

  logic [3:0]     sw_pc [NSW];
  logic [7:0]     sw_r0 [NSW];
  logic [NSW-1:0] sw_h;

  for (genvar g = 0; g < NSW; g++) begin : g_sw
    cpu8_core #(.DMEM_AW(4), .PROGRAM(sweep_prog(g % 16, g / 16))) i_cpu8_core (
      .clk(clk), .rst_n(rst_n), .dbg_pc(sw_pc[g]), .dbg_r0(sw_r0[g]), .dbg_halted(sw_h[g]));
  end

  // ---------- checking ----------
  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_all_halted();
    bit done;
    done = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (m_h && j_h && (&sw_h)) begin done = 1; break; end
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog actual=0x0 expected=0x1 (cores did not halt)");
    end
  endtask

  task automatic check_results(input string tag);
    chk("R5", {tag, " mem r0"}, 32'(m_r0), 32'h99);
    chk("R8", {tag, " mem pc"}, 32'(m_pc), 32'd10);
    chk("R6", {tag, " jmp r0"}, 32'(j_r0), 32'h04);
    chk("R9", {tag, " jmp pc"}, 32'(j_pc), 32'd14);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL R1 global watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset pc", 32'(m_pc), 32'd0);
    chk("R1", "reset r0", 32'(m_r0), 32'd0);
    chk("R1", "reset halted", 32'(m_h), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pc just after release", 32'(m_pc), 32'd0);

    wait_all_halted();
    check_results("run1");
    chk("R7", "mem halted", 32'(m_h), 32'd1);

    // R3/R4/R2 sweep over every function code and four patterns
    for (int g = 0; g < NSW; g++) begin
      logic [7:0] e;
      e = alu_ref(g % 16, pat_a(g / 16), pat_b(g / 16), pat_c(g / 16));
      chk((g % 16 == 2 || g % 16 == 3) ? "R4" : "R3",
          $sformatf("sweep fn=%0d pat=%0d r0", g % 16, g / 16), 32'(sw_r0[g]), 32'(e));
      chk("R7", $sformatf("sweep fn=%0d pat=%0d pc", g % 16, g / 16), 32'(sw_pc[g]), 32'd7);
    end

    // R7: frozen after halt
    repeat (30) @(negedge clk);
    chk("R7", "hold r0", 32'(m_r0), 32'h99);
    chk("R7", "hold pc", 32'(m_pc), 32'd10);
    chk("R7", "hold jmp r0", 32'(j_r0), 32'h04);

    // R10: reset and rerun
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "rereset pc", 32'(m_pc), 32'd0);
    chk("R10", "rereset r0", 32'(m_r0), 32'd0);
    chk("R10", "rereset halted", 32'(m_h), 32'd0);
    rst_n = 1'b1;
    wait_all_halted();
    check_results("run2");
    chk("R10", "sweep0 rerun r0", 32'(sw_r0[0]), 32'(alu_ref(0, 8'h00, 8'h00, 1'b0)));

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule